// File: doc/BRIEF.md
# Multi-Lane Elastic Deskew Buffer

This block sits on the receive side of a multi-lane serial link. Each lane delivers one data word per clock, together with its lock flags and a boundary marker. Each lane has its own elastic FIFO. No lane stores anything until every lane is locked. After that, each lane starts storing at its own first boundary marker. Once all lanes are storing, the FIFOs are released together when an internal multiblock phase counter reaches a programmed release offset. From then on, every lane is read in lockstep each cycle, so the lanes come out aligned with a latency that is the same at every link-up.

Two framing modes are supported. In the default 66-bit-block mode, a lane counts as locked only when its block, multiblock and extended-multiblock lock flags are all high. Storing then starts on that lane's extended-multiblock start marker. In the 8b/10b mode, only the block (code-group) lock flag is used, and storing starts on the lane's alignment-sequence start marker.

If any lane drops lock, the whole block returns to waiting and flushes every FIFO. A sticky error flag records that a lane's FIFO filled up before release.

Top module: `lane_deskew_buffer`

## Requirements
- R1: While any lane is not locked, `link_state` stays 0 (waiting) and no lane stores data. In the default mode (`mode_8b`=0), a lane is locked when `blk_lock`, `mb_lock` and `emb_lock` are all high for that lane.
- R2: On the clock edge after every lane is locked, `link_state` becomes 1 (buffering). From that cycle on, each lane stores its input word starting with the first cycle its start marker is high, and then stores every following word. Markers seen before that cycle are ignored.
- R3: An internal phase counter is 0 after reset, rises by one each cycle and wraps from MB_LEN-1 to 0. Release takes place at the first edge where the phase equals `rbd` and every lane had already started storing before that cycle. From the next cycle, `link_state` is 2.
- R4: While `link_state` is 2, `aligned_valid` is 1. Lane i of `aligned_data` (bits i*DW and up) shows that lane's oldest stored word. Every lane pops one word and stores its new input word each cycle.
- R5: With `mode_8b`=1, only `blk_lock` decides lock, and `ila_start` replaces `emb_start` as the start marker. `mb_lock`, `emb_lock` and `emb_start` have no effect.
- R6: If any lane loses lock while `link_state` is 1 or 2, the block returns to 0 on the next edge, every FIFO is emptied, and `aligned_valid` drops.
- R7: `ovf_err` is set when a lane must store a word while its FIFO holds DEPTH words before release. It stays set until `clr_err` is high at an edge with no new overflow in that cycle.
- R8: `link_state` encodes 0 = waiting for lock, 1 = buffering, 2 = released. It is 0, with `aligned_valid` and `ovf_err` at 0, after reset.
- R9: With `rbd`=0, release happens on the multiblock edge itself, at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_8b | input | 1 | 1 selects 8b/10b framing, 0 selects 66-bit-block framing |
| rbd | input | $clog2(MB_LEN) | Release offset from the phase-0 edge |
| clr_err | input | 1 | Clears the sticky overflow flag |
| lane_data | input | LANES*DW | One word per lane per cycle |
| blk_lock | input | LANES | Per-lane block / code-group lock |
| mb_lock | input | LANES | Per-lane multiblock lock |
| emb_lock | input | LANES | Per-lane extended multiblock lock |
| emb_start | input | LANES | Per-lane extended multiblock start marker |
| ila_start | input | LANES | Per-lane alignment-sequence start marker |
| aligned_data | output | LANES*DW | Lane-aligned output words |
| aligned_valid | output | 1 | Output words valid (released) |
| link_state | output | 2 | 0 waiting, 1 buffering, 2 released |
| ovf_err | output | 1 | Sticky FIFO overflow flag |

## Verification
Several properties are checked on every cycle: the state falls to waiting after any lost lock, every FIFO is empty while waiting, FIFO fill levels are frozen while released, release happens only at the programmed phase, and the error flag is sticky and only rises while buffering. The exact word each lane starts storing with, which markers are ignored, the order of words at the aligned output, and the way the two framing modes choose their lock and marker inputs can only be shown by the bench's scenarios. Those scenarios are compared against its queue-based model.

// File: rtl/lda_pkg.sv
package lda_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_BUFF = 2'd1,
    ST_RUN  = 2'd2
  } lda_state_e;
endpackage

// File: rtl/lda_phase_ctr.sv
module lda_phase_ctr #(
  parameter int MB_LEN = 16,
  parameter int CW     = $clog2(MB_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] phase
);
  localparam logic [CW-1:0] LAST = CW'(MB_LEN - 1);

  logic [CW-1:0] phase_q, phase_d;

  always_comb begin
    if (phase_q == LAST) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/lda_lane_gate.sv
module lda_lane_gate #(
  parameter int LANES = 4
) (
  input  logic             mode_8b,
  input  logic [LANES-1:0] blk_lock,
  input  logic [LANES-1:0] mb_lock,
  input  logic [LANES-1:0] emb_lock,
  input  logic [LANES-1:0] emb_start,
  input  logic [LANES-1:0] ila_start,
  output logic [LANES-1:0] mark,
  output logic             all_al
);
  logic [LANES-1:0] lane_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (mode_8b) begin
        lane_ok[i] = blk_lock[i];
        mark[i]    = ila_start[i];
      end else begin
        lane_ok[i] = blk_lock[i] & mb_lock[i] & emb_lock[i];
        mark[i]    = emb_start[i];
      end
    end
  end

  assign all_al = &lane_ok;
endmodule

// File: rtl/lda_lane_fifo.sv
module lda_lane_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            push,
  input  logic            pop,
  input  logic [DW-1:0]   din,
  output logic [DW-1:0]   dout,
  output logic [CNTW-1:0] fill,
  output logic            ovf
);
  localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            full, wr_en, rd_en;

  assign full  = (cnt_q == CNT_FULL);
  assign rd_en = pop & (cnt_q != '0) & ~flush;
  assign wr_en = push & (~full | rd_en) & ~flush;
  assign ovf   = push & full & ~rd_en & ~flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_en) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (rd_en) rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];
  assign fill = cnt_q;
endmodule

// File: rtl/lda_ctrl.sv
module lda_ctrl #(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    all_al,
  input  logic                    rel_hit,
  input  logic                    clr_err,
  input  logic [LANES-1:0]        mark,
  input  logic [LANES-1:0]        ovf,
  output lda_pkg::lda_state_e     state,
  output logic [LANES-1:0]        push,
  output logic [LANES-1:0]        pop,
  output logic                    flush,
  output logic                    err
);
  import lda_pkg::*;

  lda_state_e       state_q, state_d;
  logic [LANES-1:0] started_q, started_d;
  logic             err_q, err_d;

  always_comb begin
    state_d   = state_q;
    started_d = started_q;
    push      = '0;
    pop       = '0;
    flush     = 1'b0;
    err_d     = (err_q & ~clr_err) | (|ovf);
    case (state_q)
      ST_WAIT: begin
        flush     = 1'b1;
        started_d = '0;
        if (all_al) state_d = ST_BUFF;
      end
      ST_BUFF: begin
        if (!all_al) begin
          flush     = 1'b1;
          started_d = '0;
          state_d   = ST_WAIT;
        end else begin
          push      = started_q | mark;
          started_d = started_q | mark;
          if ((&started_q) && rel_hit) state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!all_al) begin
          flush     = 1'b1;
          started_d = '0;
          state_d   = ST_WAIT;
        end else begin
          push = '1;
          pop  = '1;
        end
      end
      default: begin
        flush     = 1'b1;
        started_d = '0;
        state_d   = ST_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_WAIT;
      started_q <= '0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      started_q <= started_d;
      err_q     <= err_d;
    end
  end

  assign state = state_q;
  assign err   = err_q;
endmodule

// File: rtl/lane_deskew_buffer.sv
module lane_deskew_buffer #(
  parameter int LANES  = 4,
  parameter int DW     = 8,
  parameter int DEPTH  = 32,
  parameter int MB_LEN = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_8b,
  input  logic [$clog2(MB_LEN)-1:0]   rbd,
  input  logic                        clr_err,
  input  logic [LANES*DW-1:0]         lane_data,
  input  logic [LANES-1:0]            blk_lock,
  input  logic [LANES-1:0]            mb_lock,
  input  logic [LANES-1:0]            emb_lock,
  input  logic [LANES-1:0]            emb_start,
  input  logic [LANES-1:0]            ila_start,
  output logic [LANES*DW-1:0]         aligned_data,
  output logic                        aligned_valid,
  output logic [1:0]                  link_state,
  output logic                        ovf_err
);
  import lda_pkg::*;

  localparam int CW   = $clog2(MB_LEN);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [CW-1:0]         phase;
  logic                  all_al, rel_hit, flush;
  logic [LANES-1:0]      mark, push, pop, ovf;
  lda_state_e            state;
  logic [LANES*DW-1:0]   head;
  logic [LANES*CNTW-1:0] fill_flat;

  lda_phase_ctr #(.MB_LEN(MB_LEN), .CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase)
  );

  lda_lane_gate #(.LANES(LANES)) u_gate (
    .mode_8b(mode_8b), .blk_lock(blk_lock), .mb_lock(mb_lock),
    .emb_lock(emb_lock), .emb_start(emb_start), .ila_start(ila_start),
    .mark(mark), .all_al(all_al)
  );

  assign rel_hit = (phase == rbd);

  lda_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .all_al(all_al), .rel_hit(rel_hit),
    .clr_err(clr_err), .mark(mark), .ovf(ovf), .state(state),
    .push(push), .pop(pop), .flush(flush), .err(ovf_err)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_fifo
    lda_lane_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(push[i]), .pop(pop[i]),
      .din(lane_data[i*DW +: DW]), .dout(head[i*DW +: DW]),
      .fill(fill_flat[i*CNTW +: CNTW]), .ovf(ovf[i])
    );
  end

  assign aligned_valid = (state == ST_RUN);
  assign aligned_data  = aligned_valid ? head : '0;
  assign link_state    = state;
endmodule

// File: rtl/lane_deskew_buffer_chk.sv
module lane_deskew_buffer_chk #(
  parameter int LANES = 4,
  parameter int CW    = 4,
  parameter int CNTW  = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  all_al,
  input logic [CW-1:0]         phase,
  input logic [CW-1:0]         rbd,
  input logic [LANES*CNTW-1:0] fill,
  input logic [1:0]            link_state,
  input logic                  aligned_valid,
  input logic                  ovf_err,
  input logic                  clr_err
);
  // R1
  wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_al |=> link_state == 2'd0);

  // R3
  release_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_valid) |-> $past(phase) == $past(rbd));

  // R6
  wait_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_state == 2'd0 |-> fill == '0);

  // R4
  run_fill_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd2 && $past(link_state) == 2'd2) |-> fill == $past(fill));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !clr_err) |=> ovf_err);

  // R7
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(link_state) == 2'd1);

  // R8
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_state != 2'd3);
endmodule

bind lane_deskew_buffer lane_deskew_buffer_chk #(.LANES(LANES), .CW(CW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .all_al(all_al), .phase(phase), .rbd(rbd),
  .fill(fill_flat), .link_state(link_state), .aligned_valid(aligned_valid),
  .ovf_err(ovf_err), .clr_err(clr_err)
);

// File: tb/lane_deskew_buffer_test.sv
`timescale 1ns/1ps
module lane_deskew_buffer_test;
  localparam int LANES = 4, DW = 8, DEPTH = 32, MB_LEN = 16, CW = 4;

  logic clk, rst_n, mode_8b, clr_err;
  logic [CW-1:0] rbd;
  logic [LANES*DW-1:0] lane_data, aligned_data;
  logic [LANES-1:0] blk_lock, mb_lock, emb_lock, emb_start, ila_start, mark_en;
  logic aligned_valid, ovf_err;
  logic [1:0] link_state;

  int errors = 0, checks = 0, t = 100;
  int skew [LANES] = '{0, 2, 3, 5};
  string cur_req = "R8";
  bit done = 0;

  // model state
  int m_state, m_cnt;
  bit m_err, m_ovf, m_al, m_rel;
  logic [LANES-1:0] m_started, m_mk;
  logic [DW-1:0] q [LANES][$];

  lane_deskew_buffer #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH), .MB_LEN(MB_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .mode_8b(mode_8b), .rbd(rbd), .clr_err(clr_err),
    .lane_data(lane_data), .blk_lock(blk_lock), .mb_lock(mb_lock), .emb_lock(emb_lock),
    .emb_start(emb_start), .ila_start(ila_start), .aligned_data(aligned_data),
    .aligned_valid(aligned_valid), .link_state(link_state), .ovf_err(ovf_err)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_err = 0; m_started = '0;
      for (int i = 0; i < LANES; i++) q[i].delete();
    end else begin
      m_al = 1; m_ovf = 0;
      for (int i = 0; i < LANES; i++) begin
        if (mode_8b) m_al = m_al & blk_lock[i];
        else         m_al = m_al & blk_lock[i] & mb_lock[i] & emb_lock[i];
        m_mk[i] = mode_8b ? ila_start[i] : emb_start[i];
      end
      m_rel = (&m_started) && (m_cnt == int'(rbd));
      if (m_state != 0 && !m_al) begin
        m_state = 0; m_started = '0;
        for (int i = 0; i < LANES; i++) q[i].delete();
      end else if (m_state == 0) begin
        if (m_al) m_state = 1;
      end else if (m_state == 1) begin
        for (int i = 0; i < LANES; i++) begin
          if (m_started[i] || m_mk[i]) begin
            if (q[i].size() < DEPTH) q[i].push_back(lane_data[i*DW +: DW]);
            else m_ovf = 1;
          end
        end
        m_started = m_started | m_mk;
        if (m_rel) m_state = 2;
      end else begin
        for (int i = 0; i < LANES; i++) begin
          void'(q[i].pop_front());
          q[i].push_back(lane_data[i*DW +: DW]);
        end
      end
      m_err = (m_err && !clr_err) || m_ovf;
      m_cnt = (m_cnt == MB_LEN - 1) ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("link_state", int'(link_state), m_state);
    chk("aligned_valid", int'(aligned_valid), (m_state == 2) ? 1 : 0);
    chk("ovf_err", int'(ovf_err), int'(m_err));
    if (m_state == 2 && aligned_valid)
      for (int i = 0; i < LANES; i++)
        chk($sformatf("lane%0d word", i), int'(aligned_data[i*DW +: DW]),
            (q[i].size() > 0) ? int'(q[i][0]) : -1);
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      t++;
      for (int i = 0; i < LANES; i++) begin
        lane_data[i*DW +: DW] = DW'(t - skew[i]);
        emb_start[i] = mark_en[i] && (((t - skew[i]) % MB_LEN) == 0) && !mode_8b;
        ila_start[i] = mark_en[i] && (((t - skew[i]) % MB_LEN) == 0) && mode_8b;
      end
    end
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_8b = 0; clr_err = 0; rbd = '0;
    lane_data = '0; blk_lock = '0; mb_lock = '0; emb_lock = '0;
    emb_start = '0; ila_start = '0; mark_en = '1;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("reset state", int'(link_state), 0);
    chk("reset valid", int'(aligned_valid), 0);
    chk("reset err", int'(ovf_err), 0);
    rst_n = 1;
    cyc(3);

    // R1: one lane missing extended multiblock lock, markers flowing
    cur_req = "R1";
    blk_lock = '1; mb_lock = '1; emb_lock = 4'b0111;
    cyc(20);
    chk("still waiting", int'(link_state), 0);

    // R2 / R9: lock all, release at phase 0
    cur_req = "R2";
    emb_lock = '1;
    cyc(8);
    cur_req = "R9";
    cyc(30);
    chk("released rbd0", int'(link_state), 2);
    cur_req = "R4";
    cyc(30);

    // R6: lose lock on one lane
    cur_req = "R6";
    mb_lock[1] = 0;
    cyc(1);
    mb_lock[1] = 1; emb_lock[2] = 0;
    cyc(4);
    chk("dropped to wait", int'(link_state), 0);

    // R3: nonzero release offset
    cur_req = "R3";
    rbd = 4'd7; emb_lock = '1;
    cyc(45);
    chk("released rbd7", int'(link_state), 2);
    cyc(20);

    // R5: 8b/10b framing, multiblock flags ignored
    cur_req = "R5";
    blk_lock = '0;
    cyc(2);
    mode_8b = 1; mb_lock = '0; emb_lock = 4'b0101; rbd = 4'd3;
    cyc(5);
    blk_lock = '1;
    cyc(45);
    chk("8b released", int'(link_state), 2);
    cyc(20);

    // R7: one lane never starts -> overflow, sticky, then clear
    cur_req = "R7";
    mode_8b = 0; mb_lock = '1; emb_lock = '1; blk_lock = '0;
    cyc(2);
    mark_en = 4'b0111; blk_lock = '1;
    cyc(70);
    chk("overflow set", int'(ovf_err), 1);
    blk_lock[0] = 0;
    cyc(5);
    chk("sticky in wait", int'(ovf_err), 1);
    clr_err = 1;
    cyc(1);
    clr_err = 0;
    cyc(3);
    chk("cleared", int'(ovf_err), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule